// File: doc/BRIEF.md
# System Control Port with A20 Gate and Reset Pulse

This block holds the 8-bit system control port of a keyboard-style peripheral controller. Two of its bits have a direct effect on the system:

- **Bit 1** drives the A20 address gate, which is output as a level.
- **Bit 0** is the run/reset bit. Driving it low through a port write asks the system to reset.

Port bits 4 and 5 are not stored. Each clock they are refreshed from the controller's keyboard-buffer-full and auxiliary-buffer-full flags. The current port value is output so the controller can return it on a read-back command.

The controller's command path passes each command byte in with a valid strobe, and this block decodes the codes it cares about:

- Two codes force A20 on or off.
- A group of sixteen codes with the upper nibble all ones asks for a low pulse on the port's low nibble. Of that group, only bit 0 matters: a clear bit 0 starts a system reset pulse. A set bit 0 does nothing.

The data byte that follows a port-write command arrives on a separate write strobe. The reset request is a registered active-high pulse. Its length in cycles is derived from the clock frequency and a nominal duration of a few microseconds. A request that arrives while a pulse is running neither restarts nor extends it.

Top module: `sysport_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the port reads 0xCF, the A20 gate is high and the reset pulse is low.
- R2: The A20 gate output always equals bit 1 of the port value.
- R3: A port write updates bits 7:6 and 3:0 of the port to the written byte on the next cycle; bits 5:4 of the written byte are discarded.
- R4: A port write whose bit 0 is 0 starts a reset pulse that is visible on the next cycle, when no pulse is running.
- R5: Command 0xDF sets port bit 1 and command 0xDD clears it on the next cycle, leaving the other stored bits unchanged.
- R6: Any command 0xF0..0xFF with bit 0 clear starts a reset pulse on the next cycle. With bit 0 set it has no effect. Bits 3:1 are ignored and the port is never changed by these commands.
- R7: Command codes other than 0xDD, 0xDF and 0xF0..0xFF change neither the port nor the reset pulse.
- R8: Port bit 4 equals the keyboard-buffer-full input and bit 5 equals the auxiliary-buffer-full input, each delayed by one register.
- R9: A reset pulse stays high for exactly PULSE_CYC cycles, where PULSE_CYC = ceil(CLK_MHZ * PULSE_NS / 1000), with a minimum of 1.
- R10: A reset request that arrives while a pulse is high, including its last cycle, is ignored. A request on the first cycle after the pulse ends starts a new pulse.
- R11: When a port write and an A20 command arrive in the same cycle, the command decides bit 1 and the write decides the other stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A controller command byte is present this cycle |
| cmd_code | input | 8 | Controller command byte |
| wr_en | input | 1 | Port write data is present this cycle |
| wr_data | input | 8 | New port value |
| kbd_full | input | 1 | Keyboard output buffer full flag |
| aux_full | input | 1 | Auxiliary output buffer full flag |
| port_val | output | 8 | Current port value for read-back |
| a20_gate | output | 1 | A20 address gate level |
| sys_reset_req | output | 1 | Active-high system reset pulse |

## Verification
The bench builds the block with CLK_MHZ = 250 and PULSE_NS = 24, which makes the pulse six cycles long. At the default setting of 1500 cycles, a per-cycle check of the whole pulse would be slow to run. With six cycles, the bench can count every high cycle of the pulse. It can also place a second request on the pulse's middle cycle, on its final cycle, and on the cycle just after it drops. The same short pulse lets the vector table clear any running pulse between entries, so each entry starts from an idle stretcher.

// File: rtl/sysport_pkg.sv
package sysport_pkg;

  localparam logic [7:0] PORT_RESET_VAL = 8'hCF;
  localparam logic [7:0] CMD_GATE_ON    = 8'hDF;
  localparam logic [7:0] CMD_GATE_OFF   = 8'hDD;
  localparam logic [3:0] PULSE_GROUP    = 4'hF;

  localparam int RUN_BIT  = 0;
  localparam int GATE_BIT = 1;
  localparam int KBF_BIT  = 4;
  localparam int AXF_BIT  = 5;

  // ceil(mhz * ns / 1000), never below one cycle
  function automatic int pulse_cycles(input int mhz, input int ns);
    int v;
    v = (mhz * ns + 999) / 1000;
    return (v < 1) ? 1 : v;
  endfunction

  function automatic logic in_pulse_group(input logic [7:0] code);
    return code[7:4] == PULSE_GROUP;
  endfunction

  // only bit 0 of a pulse-group code matters; clear means reset
  function automatic logic pulse_hits_run(input logic [7:0] code);
    return in_pulse_group(code) && !code[RUN_BIT];
  endfunction

  // stored port bits after one cycle of write and gate commands
  function automatic logic [7:0] next_port(input logic [7:0] cur,
                                           input logic       wr,
                                           input logic [7:0] data,
                                           input logic       g_on,
                                           input logic       g_off,
                                           input logic       kbf,
                                           input logic       axf);
    logic [7:0] v;
    v = wr ? data : cur;
    if (g_on)  v[GATE_BIT] = 1'b1;
    if (g_off) v[GATE_BIT] = 1'b0;
    v[KBF_BIT] = kbf;
    v[AXF_BIT] = axf;
    return v;
  endfunction

endpackage

// File: rtl/sysport_cmd_dec.sv
module sysport_cmd_dec
  import sysport_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       gate_on,
  output logic       gate_off,
  output logic       cmd_reset
);

  always_comb begin
    gate_on   = cmd_valid && (cmd_code == CMD_GATE_ON);
    gate_off  = cmd_valid && (cmd_code == CMD_GATE_OFF);
    cmd_reset = cmd_valid && pulse_hits_run(cmd_code);
  end

endmodule

// File: rtl/sysport_reg.sv
module sysport_reg
  import sysport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       gate_on,
  input  logic       gate_off,
  input  logic       kbd_full,
  input  logic       aux_full,
  output logic [7:0] port_q,
  output logic       a20_gate,
  output logic       wr_reset
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= PORT_RESET_VAL;
    else        port_q <= next_port(port_q, wr_en, wr_data, gate_on, gate_off,
                                    kbd_full, aux_full);
  end

  assign a20_gate = port_q[GATE_BIT];
  assign wr_reset = wr_en && !wr_data[RUN_BIT];

  // R5: gate commands land one cycle later
  p_gate_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |=> a20_gate);
  p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> !a20_gate);

  // R8: buffer flags appear one register later
  p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> port_q[AXF_BIT:KBF_BIT] == $past({aux_full, kbd_full}));

  // R3: written byte reaches stored bits when no gate command competes
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !gate_on && !gate_off) |=>
      (port_q[7:6] == $past(wr_data[7:6]) && port_q[3:0] == $past(wr_data[3:0])));

  // R7/R6: without write or gate command the stored bits hold
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !gate_on && !gate_off) |=>
      (port_q[7:6] == $past(port_q[7:6]) && port_q[3:0] == $past(port_q[3:0])));

endmodule

// File: rtl/sysport_pulse.sv
module sysport_pulse #(
  parameter int PULSE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active
);

  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt;
  logic          fire;

  assign fire   = req && (cnt == '0);
  assign active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (fire)    cnt <= LOAD;
    else if (active)  cnt <= cnt - CW'(1);
  end

  // R9: an idle stretcher starts on a request
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !active) |=> active);
  // R9: the last counted cycle ends the pulse
  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1) && !req) |=> !active);
  // R10: a running pulse is never reloaded
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != CW'(1)) |=> (cnt == $past(cnt) - CW'(1)));
  p_last_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1)) |=> !active);

endmodule

// File: rtl/sysport_ctl.sv
module sysport_ctl
  import sysport_pkg::*;
#(
  parameter int CLK_MHZ  = 250,
  parameter int PULSE_NS = 6000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       kbd_full,
  input  logic       aux_full,
  output logic [7:0] port_val,
  output logic       a20_gate,
  output logic       sys_reset_req
);

  localparam int PULSE_CYC = pulse_cycles(CLK_MHZ, PULSE_NS);

  logic gate_on, gate_off, cmd_reset, wr_reset, reset_req;

  sysport_cmd_dec u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .gate_on   (gate_on),
    .gate_off  (gate_off),
    .cmd_reset (cmd_reset)
  );

  sysport_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .gate_on  (gate_on),
    .gate_off (gate_off),
    .kbd_full (kbd_full),
    .aux_full (aux_full),
    .port_q   (port_val),
    .a20_gate (a20_gate),
    .wr_reset (wr_reset)
  );

  assign reset_req = cmd_reset | wr_reset;

  sysport_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (reset_req),
    .active (sys_reset_req)
  );

  // R6: pulse-group code with bit 0 clear starts a pulse
  p_cmd_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[7:4] == 4'hF && !cmd_code[0] && !sys_reset_req)
      |=> sys_reset_req);
  // R6/R7: no request source leaves an idle pulse idle
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_reset_req && !(wr_en && !wr_data[0]) &&
     !(cmd_valid && cmd_code[7:4] == 4'hF && !cmd_code[0])) |=> !sys_reset_req);
  // R4: port write with run bit low starts a pulse
  p_wr_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0] && !sys_reset_req) |=> sys_reset_req);
  // R2: gate level tracks port bit 1
  p_gate_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a20_gate == port_val[1]);

endmodule

// File: tb/sysport_ctl_test.sv
`timescale 1ns/1ps
module sysport_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       kbd_full, aux_full;
  logic [7:0] port_val;
  logic       a20_gate, sys_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int PLEN = 6;  // 250 MHz * 24 ns / 1000

  always #2 clk = ~clk;

  sysport_ctl #(.CLK_MHZ(250), .PULSE_NS(24)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_en(wr_en), .wr_data(wr_data), .kbd_full(kbd_full), .aux_full(aux_full),
    .port_val(port_val), .a20_gate(a20_gate), .sys_reset_req(sys_reset_req)
  );

  typedef struct packed {
    logic       cv;
    logic [7:0] cmd;
    logic       wv;
    logic [7:0] wd;
    logic       kb;
    logic       ax;
    logic [7:0] ep;
    logic       er;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hDD, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCD, 1'b0},  // R5 off
    '{1'b1, 8'hDF, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b0},  // R5 on
    '{1'b0, 8'h00, 1'b1, 8'h03, 1'b1, 1'b0, 8'h13, 1'b0},  // R3 R8
    '{1'b0, 8'h00, 1'b1, 8'hFE, 1'b0, 1'b1, 8'hEE, 1'b1},  // R4 R3 R8
    '{1'b0, 8'h00, 1'b1, 8'hCF, 1'b0, 1'b0, 8'hCF, 1'b0},  // R3
    '{1'b1, 8'hFE, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1},  // R6 reset
    '{1'b1, 8'hF1, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b0},  // R6 no-op
    '{1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b0},  // R6 no-op
    '{1'b1, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b1},  // R6 reset
    '{1'b1, 8'h20, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b0},  // R7
    '{1'b1, 8'hD1, 1'b0, 8'h00, 1'b0, 1'b0, 8'hCF, 1'b0},  // R7
    '{1'b1, 8'hDD, 1'b1, 8'hFF, 1'b0, 1'b0, 8'hCD, 1'b0},  // R11
    '{1'b1, 8'hDF, 1'b1, 8'h00, 1'b0, 1'b0, 8'h02, 1'b1},  // R11 R4
    '{1'b0, 8'h00, 1'b1, 8'hCF, 1'b1, 1'b1, 8'hFF, 1'b0}   // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    cmd_valid = 1'b0; wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cmd();
    cmd_valid = 1'b1; cmd_code = 8'hFE;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; wr_en = 1'b0; wr_data = '0;
    kbd_full = 1'b0; aux_full = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 port", port_val, 8'hCF);
    chk("R1 a20", a20_gate, 1'b1);
    chk("R1 rst", sys_reset_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 port after", port_val, 8'hCF);
    chk("R1 rst after", sys_reset_req, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cmd_valid = VEC[i].cv; cmd_code = VEC[i].cmd;
      wr_en = VEC[i].wv; wr_data = VEC[i].wd;
      kbd_full = VEC[i].kb; aux_full = VEC[i].ax;
      @(negedge clk);
      chk($sformatf("R3/R5/R6/R7/R8/R11 vec %0d port", i), port_val, VEC[i].ep);
      chk($sformatf("R4/R6/R7 vec %0d rst", i), sys_reset_req, VEC[i].er);
      chk($sformatf("R2 vec %0d a20", i), a20_gate, VEC[i].ep[1]);
      idle(PLEN + 2);
    end

    // R8 latency: flags change, port follows only after the edge
    kbd_full = 1'b0; aux_full = 1'b1;
    #1;
    chk("R8 before edge", port_val[5:4], 2'b11);
    @(negedge clk);
    chk("R8 after edge", port_val[5:4], 2'b10);

    // R9 pulse length
    pulse_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (sys_reset_req) hi++;
      @(negedge clk);
    end
    chk("R9 pulse length", hi, PLEN);

    // R10 mid-pulse request does not extend
    pulse_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (sys_reset_req) hi++;
      if (i == 1) pulse_cmd(); else cmd_valid = 1'b0;
      @(negedge clk);
    end
    chk("R10 mid request length", hi, PLEN);

    // R10 request on the last high cycle is ignored, next one restarts
    pulse_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (PLEN - 1) @(negedge clk);
    chk("R10 last cycle high", sys_reset_req, 1'b1);
    pulse_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 last-cycle request ignored", sys_reset_req, 1'b0);
    pulse_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 new pulse after end", sys_reset_req, 1'b1);
    chk("R6 port untouched", port_val, 8'hEF);
    idle(PLEN + 2);
    chk("R9 drained", sys_reset_req, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule